// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a general-purpose I/O controller for up to 32 lines, programmed through a simple 32-bit register port. The port carries a byte address, a write strobe, write data and combinational read data. For each line it holds a drive-enable bit, an open-drain bit and an output data bit. It samples the external pins through a multi-flop synchronizer. Line numbering is reversed against register bit numbering. Line n always lives in register bit 31-n, in every register.

Each line watches its synchronized input for transitions. A sense setting picks which transitions count: falling only, rising only, both, or none. A qualifying transition sets a sticky event bit, and software clears it by writing a one to that bit. The event bits are ANDed with an enable mask and ORed into one level-sensitive interrupt output.

A parameter selects one of two sense encodings. The default uses one bit per line. The alternative uses a two-bit code per line, split over two registers. A second parameter marks some lines as input-only, so they can never drive.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Line n maps to register bit 31-n in every register: line 0 is bit 31 and line 31 is bit 0.
- R2: The drive-enable register sits at offset 0x00. A line's output driver (`pad_oe`) is active only while its drive-enable bit is 1.
- R3: The event register sits at offset 0x0C. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as a clearing write, the event stays set.
- R4: The open-drain register is at offset 0x04 and the output data register at 0x08. A driving line with its open-drain bit at 0 drives its data bit. With the open-drain bit at 1, the line drives low for data 0 and is released (`pad_oe` = 0) for data 1.
- R5: The mask register sits at 0x10, and a mask bit of 1 enables that line. `irq` is high exactly when some event bit and its mask bit are both 1.
- R6: In the one-bit sense mode, bit 31-n of offset 0x14 selects the edges for line n: 1 means falling edges only, and 0 means both rising and falling edges.
- R7: In the two-bit sense mode, lines 0-15 use offset 0x14 and lines 16-31 use offset 0x18. The code for line n sits at bit (15 - n mod 16)*2. Code 0 flags both edges, 1 rising only, 2 falling only and 3 no edges.
- R8: Lines named in `INPUT_ONLY` ignore writes to their drive-enable bit. That bit always reads 0 and the line never drives.
- R9: A read of offset 0x08 returns, for each line, the output data bit if the line is driving and the synchronized pin value otherwise.
- R10: After reset every register reads 0, `irq` is low and no line drives. A pin change that settles before a rising edge of `clk` shows up in the event register after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | LINES | External pin levels, indexed by line |
| pad_out | output | LINES | Output level per line |
| pad_oe | output | LINES | Output driver enable per line |
| irq | output | 1 | Level interrupt summary |

## Verification
The bench sweeps every line with a lone one-hot drive-enable bit. This shows the reversed bit mapping and exposes which lines are forced to input-only. Each line is then toggled up and then down under each sense setting: both one-bit values, and all four two-bit codes in both sense registers. This tells rising from falling detection and each line's field position from its neighbours'. Fixed mixed patterns on drive-enable, open-drain, data and pins separate the driven and sampled halves of the data readback. Selective clears, a clear that lands in the same cycle as a new edge, and a sequence of mask changes separate write-one-to-clear from plain writes and set-priority from clear-priority, and show how the mask gates `irq`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned REG_W = 32;

   localparam logic [7:0] OFF_DRIVE_EN   = 8'h00;
   localparam logic [7:0] OFF_OPEN_DRAIN = 8'h04;
   localparam logic [7:0] OFF_DATA       = 8'h08;
   localparam logic [7:0] OFF_EVENT      = 8'h0C;
   localparam logic [7:0] OFF_MASK       = 8'h10;
   localparam logic [7:0] OFF_SENSE_LO   = 8'h14;
   localparam logic [7:0] OFF_SENSE_HI   = 8'h18;

   typedef enum logic [1:0] {
      SNS_BOTH = 2'd0,
      SNS_RISE = 2'd1,
      SNS_FALL = 2'd2,
      SNS_NONE = 2'd3
   } sense_code_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
   import gpio_pkg::*;
#(
   parameter int LINES         = 32,
   parameter bit TWO_BIT_SENSE = 1'b0
) (
   input  logic [REG_W-1:0] sense_lo,
   input  logic [REG_W-1:0] sense_hi,
   output logic [LINES-1:0] rise_en,
   output logic [LINES-1:0] fall_en
);
   for (genvar n = 0; n < LINES; n++) begin : g_line
      if (TWO_BIT_SENSE) begin : g_code
         localparam int SH = (15 - (n % 16)) * 2;
         logic [1:0] code;
         if (n < 16) begin : g_lo
            assign code = sense_lo[SH+1:SH];
         end else begin : g_hi
            assign code = sense_hi[SH+1:SH];
         end
         assign rise_en[n] = (code == SNS_BOTH) || (code == SNS_RISE);
         assign fall_en[n] = (code == SNS_BOTH) || (code == SNS_FALL);
      end else begin : g_flag
         assign fall_en[n] = 1'b1;
         assign rise_en[n] = ~sense_lo[REG_W-1-n];
      end
   end

   if (!TWO_BIT_SENSE) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^sense_hi;
   end
endmodule

// File: rtl/gpio_event.sv
module gpio_event
   import gpio_pkg::*;
#(
   parameter int LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] sync_in,
   input  logic [LINES-1:0] rise_en,
   input  logic [LINES-1:0] fall_en,
   input  logic [REG_W-1:0] clr_bits,
   output logic [REG_W-1:0] events
);
   logic [LINES-1:0] prev_q;
   logic [REG_W-1:0] set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   always_comb begin
      set_bits = '0;
      for (int n = 0; n < LINES; n++) begin
         set_bits[REG_W-1-n] = (rise_en[n] &  sync_in[n] & ~prev_q[n])
                             | (fall_en[n] & ~sync_in[n] &  prev_q[n]);
      end
   end

   // a fresh edge wins over a clear landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) events <= '0;
      else        events <= (events & ~clr_bits) | set_bits;
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_pkg::*;
#(
   parameter int             LINES         = 32,
   parameter int             ADDR_W        = 5,
   parameter int             SYNC_STAGES   = 2,
   parameter bit             TWO_BIT_SENSE = 1'b0,
   parameter logic [LINES-1:0] INPUT_ONLY  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   output logic              irq
);
   if (LINES < 1 || LINES > 32) begin : g_bad_lines
      $error("gpio_edge_ctrl: LINES must be 1..32");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("gpio_edge_ctrl: ADDR_W must be 5..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_ctrl: SYNC_STAGES must be at least 2");
   end

   function automatic logic [REG_W-1:0] line_to_reg(input logic [LINES-1:0] v);
      logic [REG_W-1:0] r;
      r = '0;
      for (int n = 0; n < LINES; n++) r[REG_W-1-n] = v[n];
      return r;
   endfunction

   localparam logic [REG_W-1:0] LIVE_REG  = line_to_reg({LINES{1'b1}});
   localparam logic [REG_W-1:0] IO_REG    = line_to_reg(INPUT_ONLY);
   localparam logic [REG_W-1:0] DIR_WMASK = LIVE_REG & ~IO_REG;

   logic [REG_W-1:0] dir_q, od_q, dout_q, mask_q, sense_lo_q, sense_hi_q;
   logic [REG_W-1:0] events, clr_bits, sync_reg;
   logic [LINES-1:0] sync_line, rise_en, fall_en;

   function automatic logic hit(input logic [7:0] off);
      return bus_we && (bus_addr == off[ADDR_W-1:0]);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= '0;
         od_q       <= '0;
         dout_q     <= '0;
         mask_q     <= '0;
         sense_lo_q <= '0;
         sense_hi_q <= '0;
      end else begin
         if (hit(OFF_DRIVE_EN))   dir_q      <= bus_wdata & DIR_WMASK;
         if (hit(OFF_OPEN_DRAIN)) od_q       <= bus_wdata;
         if (hit(OFF_DATA))       dout_q     <= bus_wdata;
         if (hit(OFF_MASK))       mask_q     <= bus_wdata;
         if (hit(OFF_SENSE_LO))   sense_lo_q <= bus_wdata;
         if (hit(OFF_SENSE_HI))   sense_hi_q <= bus_wdata;
      end
   end

   assign clr_bits = hit(OFF_EVENT) ? bus_wdata : '0;

   gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_line)
   );

   gpio_sense #(.LINES(LINES), .TWO_BIT_SENSE(TWO_BIT_SENSE)) u_sense (
      .sense_lo(sense_lo_q), .sense_hi(sense_hi_q),
      .rise_en(rise_en), .fall_en(fall_en)
   );

   gpio_event #(.LINES(LINES)) u_event (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_line),
      .rise_en(rise_en), .fall_en(fall_en),
      .clr_bits(clr_bits), .events(events)
   );

   assign sync_reg = line_to_reg(sync_line);

   for (genvar n = 0; n < LINES; n++) begin : g_pad
      localparam int B = REG_W - 1 - n;
      assign pad_out[n] = dout_q[B] & ~od_q[B];
      assign pad_oe[n]  = dir_q[B] & ~(od_q[B] & dout_q[B]);
   end

   always_comb begin
      unique case (bus_addr)
         OFF_DRIVE_EN[ADDR_W-1:0]:   bus_rdata = dir_q;
         OFF_OPEN_DRAIN[ADDR_W-1:0]: bus_rdata = od_q;
         OFF_DATA[ADDR_W-1:0]:       bus_rdata = (dout_q & dir_q) | (sync_reg & ~dir_q);
         OFF_EVENT[ADDR_W-1:0]:      bus_rdata = events;
         OFF_MASK[ADDR_W-1:0]:       bus_rdata = mask_q;
         OFF_SENSE_LO[ADDR_W-1:0]:   bus_rdata = sense_lo_q;
         OFF_SENSE_HI[ADDR_W-1:0]:   bus_rdata = sense_hi_q;
         default:                    bus_rdata = '0;
      endcase
   end

   assign irq = |(events & mask_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int               LINES      = 32,
   parameter int               ADDR_W     = 5,
   parameter logic [LINES-1:0] INPUT_ONLY = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [LINES-1:0]  pad_oe,
   input logic [LINES-1:0]  pad_out,
   input logic              irq,
   input logic [REG_W-1:0]  dir_q,
   input logic [REG_W-1:0]  od_q,
   input logic [REG_W-1:0]  mask_q,
   input logic [REG_W-1:0]  events
);
   logic [LINES-1:0] dir_line, od_line;
   always_comb begin
      for (int n = 0; n < LINES; n++) begin
         dir_line[n] = dir_q[REG_W-1-n];
         od_line[n]  = od_q[REG_W-1-n];
      end
   end

   // R3: without a write to the event register no pending event is lost
   p_ev_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == OFF_EVENT[ADDR_W-1:0])
      |=> ((events & $past(events)) == $past(events)));

   // R2: a line drives only while its drive-enable bit is set
   p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_line) == '0);

   // R4: an open-drain line never presents a high level
   p_od_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (od_line & pad_out) == '0);

   // R5: the interrupt needs a pending event that is also enabled
   p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((mask_q != '0) && (events != '0)));

   // R8: input-only lines never drive
   p_inonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & INPUT_ONLY) == '0);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .LINES(LINES), .ADDR_W(ADDR_W), .INPUT_ONLY(INPUT_ONLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
   .dir_q(dir_q), .od_q(od_q), .mask_q(mask_q), .events(events)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
   localparam logic [31:0] IO_A = 32'hF000_0000; // lines 28..31
   localparam logic [31:0] IO_B = 32'h0000_000F; // lines 0..3

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        we_a = 1'b0, we_b = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic [31:0] pins_a = '0, pins_b = '0;
   logic [31:0] out_a, oe_a, out_b, oe_b;
   logic        irq_a, irq_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_edge_ctrl #(.LINES(32), .TWO_BIT_SENSE(1'b0), .INPUT_ONLY(IO_A)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_a),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pin_in(pins_a),
      .pad_out(out_a), .pad_oe(oe_a), .irq(irq_a));

   gpio_edge_ctrl #(.LINES(32), .TWO_BIT_SENSE(1'b1), .INPUT_ONLY(IO_B)) dut_b (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_b),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pins_b),
      .pad_out(out_b), .pad_oe(oe_b), .irq(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a[4:0]; bus_wdata = d;
      if (b) we_b = 1'b1; else we_a = 1'b1;
      @(negedge clk);
      we_a = 1'b0; we_b = 1'b0;
   endtask

   task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a[4:0];
      #1 d = b ? rdata_b : rdata_a;
   endtask

   function automatic logic [31:0] rev(input logic [31:0] v);
      logic [31:0] r;
      for (int n = 0; n < 32; n++) r[31-n] = v[n];
      return r;
   endfunction

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      for (int a = 0; a < 7; a++) begin
         rd(0, 8'(a * 4), v); chk("R10 reset register", v, 32'h0);
      end
      chk("R10 reset irq", {31'b0, irq_a}, 32'h0);
      chk("R10 reset oe", oe_a, 32'h0);

      // R1/R2/R8: one-hot drive-enable sweep
      for (int n = 0; n < 32; n++) begin
         wr(0, 8'h00, 32'h1 << (31 - n));
         rd(0, 8'h00, v);
         e = IO_A[n] ? 32'h0 : (32'h1 << (31 - n));
         chk("R1 dir bit mapping / R8", v, e);
         chk("R2 pad_oe per line", oe_a, IO_A[n] ? 32'h0 : (32'h1 << n));
      end
      wr(0, 8'h00, 32'hFFFF_FFFF);
      rd(0, 8'h00, v); chk("R8 input-only dir dut", v, ~rev(IO_A));
      wr(1, 8'h00, 32'hFFFF_FFFF);
      rd(1, 8'h00, v); chk("R8 input-only dir dut_b", v, ~rev(IO_B));
      chk("R8 input-only oe dut_b", oe_b & IO_B, 32'h0);

      // R4: open-drain mix
      wr(0, 8'h04, 32'hFFFF_0000);
      wr(0, 8'h08, 32'hAAAA_AAAA);
      begin
         logic [31:0] eo, ee;
         for (int n = 0; n < 32; n++) begin
            logic od, dt, dr;
            od = n < 16; dt = 32'hAAAA_AAAA >> (31 - n); dr = !IO_A[n];
            eo[n] = dt & !od;
            ee[n] = dr & !(od & dt);
         end
         chk("R4 pad_out open-drain", out_a, eo);
         chk("R4 pad_oe open-drain", oe_a, ee);
      end
      wr(0, 8'h04, 32'h0);

      // R9: data readback mix
      wr(0, 8'h00, 32'hFFFF_0000);
      wr(0, 8'h08, 32'h1234_5678);
      @(negedge clk); pins_a = 32'hA5C3_0F96;
      repeat (4) @(negedge clk);
      rd(0, 8'h08, v);
      chk("R9 data readback", v, (32'h1234_5678 & 32'hFFFF_0000) | (rev(32'hA5C3_0F96) & 32'h0000_FFFF));
      @(negedge clk); pins_a = '0;
      repeat (4) @(negedge clk);
      wr(0, 8'h00, 32'h0);

      // R6: one-bit sense sweep, odd lines falling only
      wr(0, 8'h14, 32'h5555_5555);
      wr(0, 8'h0C, 32'hFFFF_FFFF);
      for (int n = 0; n < 32; n++) begin
         logic fo;
         fo = 32'h5555_5555 >> (31 - n);
         @(negedge clk); pins_a[n] = 1'b1;
         repeat (4) @(negedge clk);
         rd(0, 8'h0C, v); chk("R6 rising edge", v, fo ? 32'h0 : (32'h1 << (31 - n)));
         wr(0, 8'h0C, 32'hFFFF_FFFF);
         @(negedge clk); pins_a[n] = 1'b0;
         repeat (4) @(negedge clk);
         rd(0, 8'h0C, v); chk("R6 falling edge", v, 32'h1 << (31 - n));
         wr(0, 8'h0C, 32'hFFFF_FFFF);
         rd(0, 8'h0C, v); chk("R3 clear all", v, 32'h0);
      end

      // R3: selective clear, zero write has no effect
      @(negedge clk); pins_a[4] = 1'b1; pins_a[6] = 1'b1;
      repeat (4) @(negedge clk);
      wr(0, 8'h0C, 32'h0);
      rd(0, 8'h0C, v); chk("R3 zero write keeps events", v, 32'h0A00_0000);
      wr(0, 8'h0C, 32'h0800_0000);
      rd(0, 8'h0C, v); chk("R3 selective clear", v, 32'h0200_0000);

      // R5: mask gating (line 6 pending, bit 25)
      wr(0, 8'h10, 32'h0);
      chk("R5 irq masked", {31'b0, irq_a}, 32'h0);
      wr(0, 8'h10, 32'h0200_0000);
      chk("R5 irq enabled", {31'b0, irq_a}, 32'h1);
      wr(0, 8'h10, 32'hFDFF_FFFF);
      chk("R5 irq other lines", {31'b0, irq_a}, 32'h0);
      wr(0, 8'h10, 32'h0200_0000);
      wr(0, 8'h0C, 32'hFFFF_FFFF);
      chk("R5 irq after clear", {31'b0, irq_a}, 32'h0);

      // R3/R10: edge lands in the same cycle as a clearing write
      @(negedge clk); pins_a[8] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 5'h0C; bus_wdata = 32'hFFFF_FFFF; we_a = 1'b1;
      @(negedge clk); we_a = 1'b0;
      rd(0, 8'h0C, v); chk("R3 set wins over clear", v, 32'h0080_0000);
      wr(0, 8'h0C, 32'hFFFF_FFFF);

      // R7: two-bit sense sweep on dut_b
      for (int n = 0; n < 32; n++) begin
         for (int c = 0; c < 4; c++) begin
            logic [31:0] f;
            logic sr, sf;
            f = 32'(c) << ((15 - (n % 16)) * 2);
            wr(1, 8'h14, n < 16 ? f : 32'h0);
            wr(1, 8'h18, n < 16 ? 32'h0 : f);
            wr(1, 8'h0C, 32'hFFFF_FFFF);
            sr = (c == 0) || (c == 1);
            sf = (c == 0) || (c == 2);
            @(negedge clk); pins_b[n] = 1'b1;
            repeat (4) @(negedge clk);
            rd(1, 8'h0C, v); chk("R7 two-bit rising", v, sr ? (32'h1 << (31 - n)) : 32'h0);
            wr(1, 8'h0C, 32'hFFFF_FFFF);
            @(negedge clk); pins_b[n] = 1'b0;
            repeat (4) @(negedge clk);
            rd(1, 8'h0C, v); chk("R7 two-bit falling", v, sf ? (32'h1 << (31 - n)) : 32'h0);
         end
      end

      done = 1'b1;
      finish_run();
   end
endmodule